// File: doc/BRIEF.md
# Transport Stream Clock Reference Extractor

This block watches a byte-wide MPEG-2 transport stream and captures the program clock reference of one selected program. Software writes the 13-bit packet identifier of the program into a small register. The parser follows each 188-byte packet from its sync byte. A packet qualifies when its identifier matches the register, its transport error flag is clear, it carries an adaptation field whose length is not zero, and that field's clock-reference flag is set. For a qualifying packet, the block takes the six clock-reference bytes and keeps the 33-bit base and the 9-bit extension. It drops the six reserved bits between them.

The 42 kept bits are `{base, extension}`. They are presented as three 16-bit words: low, middle and high. The top six bits of the high word read as zero. All three words change on the same clock edge, and a one-cycle strobe marks that edge. A downstream clock-recovery loop can therefore read a consistent value whenever it sees the strobe.

Top module: `tsclk_ref_capture`

## Requirements
- R1: The identifier register resets to 0. A write with `reg_wr` stores `reg_wdata[12:0]`, and `pid_word` reads `{3'b000, identifier}`. Write bits [15:13] are ignored.
- R2: A packet starts on a cycle with `byte_valid` and `pkt_start` both high. A packet whose first byte is not 0x47 is ignored entirely.
- R3: The packet identifier is `{byte1[4:0], byte2}`. A capture occurs only if it equals the register value at the time byte 2 is taken.
- R4: A packet with the transport error flag (byte1 bit 7) set never causes a capture.
- R5: A capture requires the adaptation-field control field (byte3 bits [5:4]) to be 10 or 11, that is, byte3 bit 5 set.
- R6: A capture requires the adaptation field length (byte 4) to be nonzero.
- R7: A capture requires the clock-reference flag (byte5 bit 4) to be set.
- R8: Bytes 6 to 11 form a 48-bit value V, most significant byte first. The base is V[47:15] and the extension is V[8:0]. With C = {base, extension} (42 bits), the words are `pcr_lo` = C[15:0], `pcr_mid` = C[31:16] and `pcr_hi` = {6'b0, C[41:32]}.
- R9: The three words and `cap_strobe` change on the clock edge that takes byte 11. The strobe is high for exactly one cycle. The words hold their value at all other times.
- R10: Cycles with `byte_valid` low are skipped. They do not advance parsing, even if `pkt_start` is high.
- R11: After reset the three words read 0 and `cap_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Stream byte present this cycle |
| byte_data | input | 8 | Stream byte |
| pkt_start | input | 1 | Marks the first byte of a packet |
| reg_wr | input | 1 | Identifier register write enable |
| reg_wdata | input | 16 | Identifier register write data |
| pid_word | output | 16 | Identifier register readback |
| pcr_lo | output | 16 | Captured value bits [15:0] |
| pcr_mid | output | 16 | Captured value bits [31:16] |
| pcr_hi | output | 16 | Captured value bits [41:32], upper six bits zero |
| cap_strobe | output | 1 | One-cycle pulse when the words update |

## Verification
The assertions check these rules on every cycle:
- A register write is reflected in the readback on the next cycle, with the reserved bits zero.
- The reserved bits of the high word stay zero.
- Every internal capture decision produces a strobe on the next cycle.
- The strobe never lasts two cycles, and the words never move without it.
- A strobe always follows an accepted byte.

Only the bench's scenarios can show which packets qualify. The bench sweeps every combination of adaptation control, error flag, clock-reference flag, field length and identifier match, and adds bad sync bytes and bubbled byte streams. It compares the words against an arithmetic split of each injected value.

// File: rtl/tsclk_pkg.sv
package tsclk_pkg;
  localparam int PID_W   = 13;
  localparam int WORD_W  = 16;
  localparam int BASE_W  = 33;
  localparam int EXT_W   = 9;
  localparam int REF_W   = BASE_W + EXT_W;
  localparam int RAW_W   = 48;
  localparam int CNT_W   = 4;
  localparam logic [7:0] SYNC_BYTE = 8'h47;
  localparam logic [CNT_W-1:0] POS_PID_HI = 4'd1;
  localparam logic [CNT_W-1:0] POS_PID_LO = 4'd2;
  localparam logic [CNT_W-1:0] POS_CTRL   = 4'd3;
  localparam logic [CNT_W-1:0] POS_AFLEN  = 4'd4;
  localparam logic [CNT_W-1:0] POS_FLAGS  = 4'd5;
  localparam logic [CNT_W-1:0] POS_REF0   = 4'd6;
  localparam logic [CNT_W-1:0] POS_REFN   = 4'd11;
  localparam logic [CNT_W-1:0] POS_DONE   = 4'd12;

  // Drops the reserved bits between the base and the extension and packs the
  // remaining 42 bits as {hi, mid, lo}.
  function automatic logic [3*WORD_W-1:0] split_ref(input logic [RAW_W-1:0] raw);
    logic [REF_W-1:0] c;
    c = {raw[RAW_W-1 -: BASE_W], raw[EXT_W-1:0]};
    return {{(3*WORD_W-REF_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/tsclk_pid_reg.sv
module tsclk_pid_reg
  import tsclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [PID_W-1:0]  pid_sel,
  output logic [WORD_W-1:0] pid_word
);
  always_ff @(posedge clk) begin
    if (!rst_n)      pid_sel <= '0;
    else if (reg_wr) pid_sel <= reg_wdata[PID_W-1:0];
  end

  assign pid_word = {{(WORD_W-PID_W){1'b0}}, pid_sel};
endmodule

// File: rtl/tsclk_hdr_parse.sv
module tsclk_hdr_parse
  import tsclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             pkt_start,
  input  logic [PID_W-1:0] pid_sel,
  output logic             cap_fire,
  output logic [RAW_W-1:0] raw_ref
);
  localparam int SH_W = RAW_W - 8;

  logic [CNT_W-1:0] pos;
  logic             active;
  logic             elig;
  logic [PID_W-9:0] pid_hi;
  logic [SH_W-1:0]  sh;
  logic             take;

  assign take = byte_valid && !pkt_start && active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      active <= 1'b0;
      elig   <= 1'b0;
      pid_hi <= '0;
      sh     <= '0;
    end else if (byte_valid && pkt_start) begin
      active <= (byte_data == SYNC_BYTE);
      elig   <= (byte_data == SYNC_BYTE);
      pos    <= POS_PID_HI;
    end else if (take) begin
      if (pos != POS_DONE) pos <= pos + 1'b1;
      if (pos == POS_PID_HI) begin
        pid_hi <= byte_data[PID_W-9:0];
        if (byte_data[7]) elig <= 1'b0;
      end
      if (pos == POS_PID_LO && {pid_hi, byte_data} != pid_sel) elig <= 1'b0;
      if (pos == POS_CTRL && !byte_data[5])                    elig <= 1'b0;
      if (pos == POS_AFLEN && byte_data == 8'h00)              elig <= 1'b0;
      if (pos == POS_FLAGS && !byte_data[4])                   elig <= 1'b0;
      if (pos >= POS_REF0 && pos < POS_REFN) sh <= {sh[SH_W-9:0], byte_data};
    end
  end

  assign cap_fire = take && elig && (pos == POS_REFN);
  assign raw_ref  = {sh, byte_data};
endmodule

// File: rtl/tsclk_ref_hold.sv
module tsclk_ref_hold
  import tsclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_fire,
  input  logic [RAW_W-1:0]  raw_ref,
  output logic [WORD_W-1:0] pcr_lo,
  output logic [WORD_W-1:0] pcr_mid,
  output logic [WORD_W-1:0] pcr_hi,
  output logic              cap_strobe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {pcr_hi, pcr_mid, pcr_lo} <= '0;
      cap_strobe <= 1'b0;
    end else begin
      cap_strobe <= cap_fire;
      if (cap_fire) {pcr_hi, pcr_mid, pcr_lo} <= split_ref(raw_ref);
    end
  end
endmodule

// File: rtl/tsclk_ref_capture.sv
module tsclk_ref_capture
  import tsclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              pkt_start,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] pid_word,
  output logic [WORD_W-1:0] pcr_lo,
  output logic [WORD_W-1:0] pcr_mid,
  output logic [WORD_W-1:0] pcr_hi,
  output logic              cap_strobe
);
  logic [PID_W-1:0] pid_sel;
  logic             cap_fire;
  logic [RAW_W-1:0] raw_ref;

  tsclk_pid_reg u_pid (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .pid_sel(pid_sel), .pid_word(pid_word)
  );

  tsclk_hdr_parse u_parse (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .pkt_start(pkt_start), .pid_sel(pid_sel), .cap_fire(cap_fire), .raw_ref(raw_ref)
  );

  tsclk_ref_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cap_fire(cap_fire), .raw_ref(raw_ref),
    .pcr_lo(pcr_lo), .pcr_mid(pcr_mid), .pcr_hi(pcr_hi), .cap_strobe(cap_strobe)
  );
endmodule

// File: rtl/tsclk_ref_capture_chk.sv
module tsclk_ref_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic [15:0] pid_word,
  input logic [15:0] pcr_lo,
  input logic [15:0] pcr_mid,
  input logic [15:0] pcr_hi,
  input logic        cap_strobe,
  input logic        cap_fire
);
  assert_pid_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> pid_word == ($past(reg_wdata) & 16'h1FFF));

  assert_pid_rsvd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pid_word[15:13] == 3'b000);

  assert_hi_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pcr_hi[15:10] == 6'b0);

  assert_fire_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> cap_strobe);

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> !cap_strobe);

  assert_words_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_strobe |-> ($stable(pcr_lo) && $stable(pcr_mid) && $stable(pcr_hi)));

  assert_strobe_after_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> $past(byte_valid));
endmodule

bind tsclk_ref_capture tsclk_ref_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .pid_word(pid_word), .pcr_lo(pcr_lo), .pcr_mid(pcr_mid),
  .pcr_hi(pcr_hi), .cap_strobe(cap_strobe), .cap_fire(cap_fire)
);

// File: tb/sim_tsclk_ref_capture.sv
`timescale 1ns/1ps
module sim_tsclk_ref_capture;
  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_valid = 1'b0, pkt_start = 1'b0, reg_wr = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] pid_word, pcr_lo, pcr_mid, pcr_hi;
  logic        cap_strobe;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;
  logic [15:0] exp_lo = 0, exp_mid = 0, exp_hi = 0;

  always #2 clk = ~clk;

  tsclk_ref_capture u0 (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .pkt_start(pkt_start), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .pid_word(pid_word),
    .pcr_lo(pcr_lo), .pcr_mid(pcr_mid), .pcr_hi(pcr_hi), .cap_strobe(cap_strobe)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_pid(input logic [15:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  function automatic logic [7:0] pkt_byte(input int i, input logic [7:0] sync, input bit tei,
      input logic [12:0] pid, input logic [1:0] afc, input logic [7:0] aflen,
      input bit pflag, input logic [47:0] raw);
    if (i == 0) return sync;
    if (i == 1) return {tei, 2'b10, pid[12:8]};
    if (i == 2) return pid[7:0];
    if (i == 3) return {2'b00, afc, 4'h5};
    if (i == 4) return aflen;
    if (i == 5) return {3'b010, pflag, 4'h0};
    if (i >= 6 && i <= 11) return raw[8*(11-i) +: 8];
    return 8'hFF;
  endfunction

  // Sends one 188-byte packet; checks the words and strobe after byte 11 and byte 12.
  task automatic send_pkt(input logic [7:0] sync, input bit tei, input logic [12:0] pid,
      input logic [1:0] afc, input logic [7:0] aflen, input bit pflag,
      input logic [47:0] raw, input bit gap, input bit want, input string req);
    logic [32:0] base;
    base = raw[47:15];
    if (want) begin
      exp_hi  = 16'(base >> 23);
      exp_mid = 16'((base >> 7) & 33'hFFFF);
      exp_lo  = 16'(((base & 33'h7F) << 9) | {24'd0, raw[8:0]});
    end
    for (int i = 0; i < 188; i++) begin
      if (gap) begin
        @(negedge clk); byte_valid = 1'b0; pkt_start = 1'b1; byte_data = 8'h47;
      end
      @(negedge clk);
      byte_valid = 1'b1; pkt_start = (i == 0);
      byte_data = pkt_byte(i, sync, tei, pid, afc, aflen, pflag, raw);
      if (i == 11) begin
        @(posedge clk); #1;
        check({req, " strobe at byte 11 (R9)"}, {63'd0, cap_strobe}, {63'd0, want});
        check({req, " words (R8)"}, {16'd0, pcr_hi, pcr_mid, pcr_lo}, {16'd0, exp_hi, exp_mid, exp_lo});
      end
      if (i == 12) begin
        @(posedge clk); #1;
        check({req, " strobe one cycle (R9)"}, {63'd0, cap_strobe}, 64'd0);
      end
    end
    @(negedge clk); byte_valid = 1'b0; pkt_start = 1'b0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<=150000", cycles);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [12:0] pid;
    logic [47:0] raw;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("r11_ reset lo", {48'd0, pcr_lo}, 0);
    check("r11_ reset mid", {48'd0, pcr_mid}, 0);
    check("r11_ reset hi", {48'd0, pcr_hi}, 0);
    check("R11 reset strobe", {63'd0, cap_strobe}, 0);
    check("R1 reset pid", {48'd0, pid_word}, 0);
    write_pid(16'hFFFF);
    check("R1 reserved write bits dropped", {48'd0, pid_word}, 64'h1FFF);
    pid = 13'h1A5C;
    write_pid({3'b111, pid});
    check("R1 readback", {48'd0, pid_word}, {51'd0, pid});

    // Near-exhaustive sweep: R3 R4 R5 R6 R7
    for (int k = 0; k < 64; k++) begin
      logic [1:0] afc; bit tei, pflag, match, gap, want; logic [7:0] aflen;
      afc = k[1:0]; tei = k[2]; pflag = k[3]; aflen = k[4] ? 8'd7 : 8'd0; match = k[5];
      gap = k[0] ^ k[3];
      raw = 48'h9E37_79B9_7F4A ^ (48'(k) * 48'h0101_0307_0B0D);
      want = match && !tei && afc[1] && (aflen != 0) && pflag;
      send_pkt(8'h47, tei, match ? pid : (pid ^ 13'h0001), afc, aflen, pflag, raw, gap, want,
               $sformatf("R3 R4 R5 R6 R7 R10 combo %0d", k));
    end
    send_pkt(8'h47, 1'b0, pid ^ 13'h1000, 2'b11, 8'd7, 1'b1, 48'h1111_2222_3333, 1'b0, 1'b0, "R3 top pid bit");
    send_pkt(8'h46, 1'b0, pid, 2'b10, 8'd7, 1'b1, 48'h4444_5555_6666, 1'b0, 1'b0, "R2 bad sync");
    send_pkt(8'h47, 1'b0, pid, 2'b10, 8'd7, 1'b1, 48'hFFFF_FFFF_FFFF, 1'b1, 1'b1, "R8 all ones");
    send_pkt(8'h47, 1'b0, pid, 2'b11, 8'd183, 1'b1, 48'h0000_0000_7E00, 1'b0, 1'b1, "R8 reserved only");
    write_pid(16'h0000);
    send_pkt(8'h47, 1'b0, pid, 2'b11, 8'd7, 1'b1, 48'hABCD_EF01_2345, 1'b0, 1'b0, "R3 old pid after rewrite");
    send_pkt(8'h47, 1'b0, 13'h0000, 2'b11, 8'd1, 1'b1, 48'h8000_0000_8001, 1'b1, 1'b1, "R1 R3 pid zero");
    repeat (3) @(negedge clk);
    check("R9 words hold idle", {16'd0, pcr_hi, pcr_mid, pcr_lo}, {16'd0, exp_hi, exp_mid, exp_lo});
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule